// File: doc/BRIEF.md
# Hardware Cursor Overlay

This block paints a small cursor on top of a display pixel stream. For every pixel the raster scan presents, it receives the x/y raster position, sync flags, a valid flag and the background colour. If the pixel lies inside the 64 by 64 cursor window and the cursor is on, it reads a 2-bit code for that pixel from an internal pattern RAM. Code 0 keeps the background. The other three codes replace the background with one of three programmed RGB565 colours, widened to 24-bit RGB.

Software sets up the cursor through four 32-bit registers and one write port into the pattern RAM. The registers hold the enable bit and a pattern base address, the cursor position, and the three colours. The result leaves the block one clock after the pixel enters it. Valid, horizontal sync and vertical sync are delayed by the same clock, so they stay aligned with the pixel data.

Top module: `cursor_overlay`

## Requirements
- R1: While reset is asserted, out_valid, out_hsync, out_vsync and out_rgb are 0, and all four registers read back as 0.
- R2: Register select 0 (control) keeps only bits 31 and 27:4 of a write. Select 1 (position) keeps bits 27:16 and 11:0. Select 2 (colours A/B) keeps all 32 bits. Select 3 (colour C) keeps bits 15:0. reg_rdata shows the register chosen by reg_addr in the same cycle.
- R3: When control bit 31 is 0, out_rgb equals bg_rgb from one clock earlier, for every raster position.
- R4: out_valid, out_hsync and out_vsync equal pix_valid, pix_hsync and pix_vsync from one clock earlier.
- R5: The cursor x is position bits 10:0 and the cursor y is position bits 26:16. A pixel is inside the window only when cursor_x <= pix_x < cursor_x + 64 and cursor_y <= pix_y < cursor_y + 64. Outside the window out_rgb is the delayed background.
- R6: Inside the window, pattern code 0 is transparent: out_rgb is the delayed background.
- R7: Code 1 selects colour A (select 2, bits 15:0). Code 2 selects colour B (select 2, bits 31:16). Code 3 selects colour C (select 3, bits 15:0).
- R8: A colour c is widened to out_rgb = {c[15:11],3'b0, c[10:5],2'b0, c[4:0],3'b0}, with red in bits 23:16 and blue in bits 7:0.
- R9: Pattern RAM word address row*4 + col/16 holds the codes for 16 pixels of one cursor row. The pixel at column offset col uses bits 2*(col%16)+1 : 2*(col%16). Here row = pix_y - cursor_y and col = pix_x - cursor_x.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select (0 control, 1 position, 2 colours A/B, 3 colour C) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the selected register |
| pat_wr_en | input | 1 | Pattern RAM write strobe |
| pat_wr_addr | input | PAT_AW (8) | Pattern RAM word address |
| pat_wr_data | input | 32 | Sixteen 2-bit codes |
| pix_valid | input | 1 | Incoming pixel valid |
| pix_hsync | input | 1 | Incoming horizontal sync |
| pix_vsync | input | 1 | Incoming vertical sync |
| pix_x | input | POS_W (12) | Raster column |
| pix_y | input | POS_W (12) | Raster line |
| bg_rgb | input | 24 | Background pixel, 8 bits per channel |
| out_valid | output | 1 | Delayed valid |
| out_hsync | output | 1 | Delayed horizontal sync |
| out_vsync | output | 1 | Delayed vertical sync |
| out_rgb | output | 24 | Overlaid pixel |

## Verification
The pixel result and the three delayed flags are due exactly one rising edge after the inputs that produce them. Register readback is combinational from the register select. A register or pattern write takes effect at the edge that accepts it. The bench changes inputs on the falling edge, and compares pixel outputs on the next falling edge, after that single register stage has loaded. Register reads are compared a short delay after reg_addr changes, within the same low phase.

// File: rtl/cursor_ovl_pkg.sv
package cursor_ovl_pkg;
   localparam int REG_W   = 32;
   localparam int RGB_W   = 24;
   localparam int COLOR_W = 16;
   localparam int CODE_W  = 2;
   localparam int EN_BIT  = 31;

   localparam logic [1:0] SEL_CTRL = 2'd0;
   localparam logic [1:0] SEL_POS  = 2'd1;
   localparam logic [1:0] SEL_CAB  = 2'd2;
   localparam logic [1:0] SEL_CC   = 2'd3;

   localparam logic [REG_W-1:0] KEEP_CTRL = 32'h8FFF_FFF0;
   localparam logic [REG_W-1:0] KEEP_POS  = 32'h0FFF_0FFF;
   localparam logic [REG_W-1:0] KEEP_CAB  = 32'hFFFF_FFFF;
   localparam logic [REG_W-1:0] KEEP_CC   = 32'h0000_FFFF;

   function automatic logic [REG_W-1:0] keep_mask(input logic [1:0] sel);
      case (sel)
         SEL_CTRL: return KEEP_CTRL;
         SEL_POS:  return KEEP_POS;
         SEL_CAB:  return KEEP_CAB;
         default:  return KEEP_CC;
      endcase
   endfunction

   function automatic logic [RGB_W-1:0] widen565(input logic [COLOR_W-1:0] c);
      return {c[15:11], 3'b000, c[10:5], 2'b00, c[4:0], 3'b000};
   endfunction
endpackage

// File: rtl/cursor_ovl_regs.sv
module cursor_ovl_regs
   import cursor_ovl_pkg::*;
#(
   parameter int LOC_BITS = 11
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [1:0]          sel,
   input  logic [REG_W-1:0]    wdata,
   output logic [REG_W-1:0]    rdata,
   output logic                enable,
   output logic [LOC_BITS-1:0] loc_x,
   output logic [LOC_BITS-1:0] loc_y,
   output logic [COLOR_W-1:0]  col_a,
   output logic [COLOR_W-1:0]  col_b,
   output logic [COLOR_W-1:0]  col_c
);
   localparam int NREG = 4;

   generate
      if (LOC_BITS < 1 || LOC_BITS > 12) begin : g_bad_loc
         $error("cursor_ovl_regs: LOC_BITS must fit a 12-bit position field");
      end
   endgenerate

   logic [REG_W-1:0] regs_q [NREG];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NREG; i++) regs_q[i] <= '0;
      end else if (wr_en) begin
         regs_q[sel] <= wdata & keep_mask(sel);
      end
   end

   assign rdata  = regs_q[sel];
   assign enable = regs_q[SEL_CTRL][EN_BIT];
   assign loc_x  = regs_q[SEL_POS][LOC_BITS-1:0];
   assign loc_y  = regs_q[SEL_POS][16 +: LOC_BITS];
   assign col_a  = regs_q[SEL_CAB][15:0];
   assign col_b  = regs_q[SEL_CAB][31:16];
   assign col_c  = regs_q[SEL_CC][15:0];
endmodule

// File: rtl/cursor_ovl_window.sv
module cursor_ovl_window #(
   parameter int  POS_W    = 12,
   parameter int  LOC_BITS = 11,
   parameter int  DIM      = 64,
   localparam int IDX_W    = $clog2(DIM)
) (
   input  logic [POS_W-1:0]    pix_x,
   input  logic [POS_W-1:0]    pix_y,
   input  logic [LOC_BITS-1:0] loc_x,
   input  logic [LOC_BITS-1:0] loc_y,
   output logic                hit,
   output logic [IDX_W-1:0]    col,
   output logic [IDX_W-1:0]    row
);
   localparam int SUM_W = ((POS_W > LOC_BITS) ? POS_W : LOC_BITS) + 1;

   logic [SUM_W-1:0] dx, dy;
   logic             in_x, in_y;

   always_comb begin
      dx   = SUM_W'(pix_x) - SUM_W'(loc_x);
      dy   = SUM_W'(pix_y) - SUM_W'(loc_y);
      in_x = (SUM_W'(pix_x) >= SUM_W'(loc_x)) && (dx < SUM_W'(DIM));
      in_y = (SUM_W'(pix_y) >= SUM_W'(loc_y)) && (dy < SUM_W'(DIM));
   end

   assign hit = in_x && in_y;
   assign col = dx[IDX_W-1:0];
   assign row = dy[IDX_W-1:0];
endmodule

// File: rtl/cursor_ovl_pattern_ram.sv
module cursor_ovl_pattern_ram #(
   parameter int DEPTH = 256,
   parameter int AW    = $clog2(DEPTH),
   parameter int DW    = 32
) (
   input  logic          clk,
   input  logic          wr_en,
   input  logic [AW-1:0] wr_addr,
   input  logic [DW-1:0] wr_data,
   input  logic [AW-1:0] rd_addr,
   output logic [DW-1:0] rd_data
);
   logic [DW-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en) mem[wr_addr] <= wr_data;
   end

   assign rd_data = mem[rd_addr];
endmodule

// File: rtl/cursor_overlay.sv
module cursor_overlay
   import cursor_ovl_pkg::*;
#(
   parameter int  POS_W    = 12,
   parameter int  CUR_DIM  = 64,
   localparam int IDX_W    = $clog2(CUR_DIM),
   localparam int LANES    = REG_W / CODE_W,
   localparam int LANE_W   = $clog2(LANES),
   localparam int WSEL_W   = IDX_W - LANE_W,
   localparam int PAT_AW   = IDX_W + WSEL_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr_en,
   input  logic [1:0]        reg_addr,
   input  logic [REG_W-1:0]  reg_wdata,
   output logic [REG_W-1:0]  reg_rdata,
   input  logic              pat_wr_en,
   input  logic [PAT_AW-1:0] pat_wr_addr,
   input  logic [REG_W-1:0]  pat_wr_data,
   input  logic              pix_valid,
   input  logic              pix_hsync,
   input  logic              pix_vsync,
   input  logic [POS_W-1:0]  pix_x,
   input  logic [POS_W-1:0]  pix_y,
   input  logic [RGB_W-1:0]  bg_rgb,
   output logic              out_valid,
   output logic              out_hsync,
   output logic              out_vsync,
   output logic [RGB_W-1:0]  out_rgb
);
   localparam int LOC_BITS  = 11;
   localparam int PAT_DEPTH = CUR_DIM << WSEL_W;
   localparam int NCOL      = 1 << CODE_W;

   generate
      if ((1 << IDX_W) != CUR_DIM || CUR_DIM < 2 * LANES) begin : g_bad_dim
         $error("cursor_overlay: CUR_DIM must be a power of two of at least two words per row");
      end
      if (POS_W < LOC_BITS) begin : g_bad_pos
         $error("cursor_overlay: POS_W narrower than the cursor position");
      end
   endgenerate

   logic                cur_enable;
   logic [LOC_BITS-1:0] loc_x, loc_y;
   logic [COLOR_W-1:0]  col_a, col_b, col_c;

   cursor_ovl_regs #(.LOC_BITS(LOC_BITS)) u_regs (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (reg_wr_en),
      .sel    (reg_addr),
      .wdata  (reg_wdata),
      .rdata  (reg_rdata),
      .enable (cur_enable),
      .loc_x  (loc_x),
      .loc_y  (loc_y),
      .col_a  (col_a),
      .col_b  (col_b),
      .col_c  (col_c)
   );

   logic             win_hit;
   logic [IDX_W-1:0] win_col, win_row;

   cursor_ovl_window #(.POS_W(POS_W), .LOC_BITS(LOC_BITS), .DIM(CUR_DIM)) u_win (
      .pix_x (pix_x),
      .pix_y (pix_y),
      .loc_x (loc_x),
      .loc_y (loc_y),
      .hit   (win_hit),
      .col   (win_col),
      .row   (win_row)
   );

   logic [PAT_AW-1:0] pat_rd_addr;
   logic [REG_W-1:0]  pat_word;
   logic [LANE_W-1:0] lane;
   logic [CODE_W-1:0] pat_code;

   assign pat_rd_addr = {win_row, win_col[IDX_W-1 -: WSEL_W]};
   assign lane        = win_col[LANE_W-1:0];

   cursor_ovl_pattern_ram #(.DEPTH(PAT_DEPTH), .AW(PAT_AW), .DW(REG_W)) u_pat (
      .clk     (clk),
      .wr_en   (pat_wr_en),
      .wr_addr (pat_wr_addr),
      .wr_data (pat_wr_data),
      .rd_addr (pat_rd_addr),
      .rd_data (pat_word)
   );

   assign pat_code = pat_word[{lane, 1'b0} +: CODE_W];

   logic [COLOR_W-1:0] col_src [1:NCOL-1];
   logic [RGB_W-1:0]   palette [NCOL];

   assign col_src[1] = col_a;
   assign col_src[2] = col_b;
   assign col_src[3] = col_c;
   assign palette[0] = bg_rgb;

   generate
      for (genvar g = 1; g < NCOL; g++) begin : g_widen
         assign palette[g] = widen565(col_src[g]);
      end
   endgenerate

   logic [RGB_W-1:0] rgb_next;
   assign rgb_next = (cur_enable && win_hit) ? palette[pat_code] : bg_rgb;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_hsync <= 1'b0;
         out_vsync <= 1'b0;
         out_rgb   <= '0;
      end else begin
         out_valid <= pix_valid;
         out_hsync <= pix_hsync;
         out_vsync <= pix_vsync;
         out_rgb   <= rgb_next;
      end
   end
endmodule

// File: rtl/cursor_overlay_chk.sv
module cursor_overlay_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        pix_valid,
   input logic        pix_hsync,
   input logic        pix_vsync,
   input logic [23:0] bg_rgb,
   input logic        out_valid,
   input logic        out_hsync,
   input logic        out_vsync,
   input logic [23:0] out_rgb,
   input logic        cur_enable,
   input logic        win_hit,
   input logic [1:0]  pat_code,
   input logic [1:0]  reg_addr,
   input logic [31:0] reg_rdata
);
   p_flags_delay_r4: assert property (@(posedge clk) disable iff (!rst_n)
      rst_n |=> {out_valid, out_hsync, out_vsync} == $past({pix_valid, pix_hsync, pix_vsync}));

   p_disabled_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !cur_enable |=> out_rgb == $past(bg_rgb));

   p_outside_pass_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !win_hit |=> out_rgb == $past(bg_rgb));

   p_transparent_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (win_hit && pat_code == 2'd0) |=> out_rgb == $past(bg_rgb));

   p_ctrl_mask_r2: assert property (@(posedge clk) disable iff (!rst_n)
      reg_addr == 2'd0 |-> (reg_rdata & 32'h7000_000F) == 32'h0);

   p_cc_mask_r2: assert property (@(posedge clk) disable iff (!rst_n)
      reg_addr == 2'd3 |-> reg_rdata[31:16] == 16'h0);
endmodule

bind cursor_overlay cursor_overlay_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .pix_valid  (pix_valid),
   .pix_hsync  (pix_hsync),
   .pix_vsync  (pix_vsync),
   .bg_rgb     (bg_rgb),
   .out_valid  (out_valid),
   .out_hsync  (out_hsync),
   .out_vsync  (out_vsync),
   .out_rgb    (out_rgb),
   .cur_enable (cur_enable),
   .win_hit    (win_hit),
   .pat_code   (pat_code),
   .reg_addr   (reg_addr),
   .reg_rdata  (reg_rdata)
);

// File: tb/cursor_overlay_tb.sv
module cursor_overlay_tb;
   localparam int CLK_PERIOD = 10;
   localparam int NVEC = 12;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        reg_wr_en;
   logic [1:0]  reg_addr;
   logic [31:0] reg_wdata;
   logic [31:0] reg_rdata;
   logic        pat_wr_en;
   logic [7:0]  pat_wr_addr;
   logic [31:0] pat_wr_data;
   logic        pix_valid, pix_hsync, pix_vsync;
   logic [11:0] pix_x, pix_y;
   logic [23:0] bg_rgb;
   logic        out_valid, out_hsync, out_vsync;
   logic [23:0] out_rgb;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   cursor_overlay u_dut (
      .clk (clk), .rst_n (rst_n),
      .reg_wr_en (reg_wr_en), .reg_addr (reg_addr), .reg_wdata (reg_wdata), .reg_rdata (reg_rdata),
      .pat_wr_en (pat_wr_en), .pat_wr_addr (pat_wr_addr), .pat_wr_data (pat_wr_data),
      .pix_valid (pix_valid), .pix_hsync (pix_hsync), .pix_vsync (pix_vsync),
      .pix_x (pix_x), .pix_y (pix_y), .bg_rgb (bg_rgb),
      .out_valid (out_valid), .out_hsync (out_hsync), .out_vsync (out_vsync), .out_rgb (out_rgb)
   );

   // colours per R8: A=F800, B=07E0, C=8A55
   localparam logic [23:0] EXP_A = 24'hF80000;
   localparam logic [23:0] EXP_B = 24'h00FC00;
   localparam logic [23:0] EXP_C = 24'h8848A8;

   // {x, y, background, expected code}; pattern code = (col + row) & 3, cursor at (100,50)
   localparam logic [49:0] VEC [NVEC] = '{
      {12'd99,  12'd50,  24'h111111, 2'd0},
      {12'd100, 12'd50,  24'h222222, 2'd0},
      {12'd101, 12'd50,  24'h333333, 2'd1},
      {12'd102, 12'd50,  24'h444444, 2'd2},
      {12'd103, 12'd50,  24'h555555, 2'd3},
      {12'd163, 12'd50,  24'h666666, 2'd3},
      {12'd164, 12'd50,  24'h777777, 2'd0},
      {12'd100, 12'd113, 24'h888888, 2'd3},
      {12'd100, 12'd114, 24'h999999, 2'd0},
      {12'd100, 12'd49,  24'hAAAAAA, 2'd0},
      {12'd120, 12'd60,  24'hBBBBBB, 2'd2},
      {12'd117, 12'd52,  24'hCCCCCC, 2'd3}
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   task automatic reg_write(input logic [1:0] sel, input logic [31:0] data);
      @(negedge clk);
      reg_wr_en = 1'b1; reg_addr = sel; reg_wdata = data;
      @(negedge clk);
      reg_wr_en = 1'b0;
   endtask

   task automatic reg_check(input string req, input logic [1:0] sel, input logic [31:0] exp);
      reg_addr = sel;
      #1;
      check(req, reg_rdata, exp);
   endtask

   task automatic apply(input string req, input logic [11:0] x, input logic [11:0] y,
                        input logic [23:0] bg, input logic [23:0] exp);
      @(negedge clk);
      pix_valid = 1'b1; pix_x = x; pix_y = y; bg_rgb = bg;
      pix_hsync = x[0]; pix_vsync = y[0];
      @(negedge clk);
      check(req, {8'h0, out_rgb}, {8'h0, exp});
      check("R4 flags", {29'h0, out_valid, out_hsync, out_vsync}, {29'h0, 1'b1, x[0], y[0]});
   endtask

   initial begin
      #(CLK_PERIOD * 20000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         summary();
      end
   end

   initial begin
      rst_n = 1'b0;
      reg_wr_en = 1'b0; reg_addr = 2'd0; reg_wdata = '0;
      pat_wr_en = 1'b0; pat_wr_addr = '0; pat_wr_data = '0;
      pix_valid = 1'b1; pix_hsync = 1'b1; pix_vsync = 1'b1;
      pix_x = 12'd101; pix_y = 12'd50; bg_rgb = 24'hDEADBE;
      repeat (3) @(negedge clk);

      // R1: reset state
      check("R1 outputs", {5'h0, out_valid, out_hsync, out_vsync, out_rgb}, 32'h0);
      for (int s = 0; s < 4; s++) reg_check("R1 regs", 2'(s), 32'h0);

      @(negedge clk);
      rst_n = 1'b1;
      pix_valid = 1'b0; pix_hsync = 1'b0; pix_vsync = 1'b0;

      // load pattern per R9: code at (col,row) = (col+row)&3
      for (int r = 0; r < 64; r++) begin
         for (int w = 0; w < 4; w++) begin
            logic [31:0] word;
            for (int k = 0; k < 16; k++) word[2*k +: 2] = 2'((16 * w + k + r) & 3);
            @(negedge clk);
            pat_wr_en = 1'b1; pat_wr_addr = 8'(r * 4 + w); pat_wr_data = word;
         end
      end
      @(negedge clk);
      pat_wr_en = 1'b0;

      // R2: field masks
      reg_write(2'd0, 32'hFFFF_FFFF);
      reg_check("R2 ctrl mask", 2'd0, 32'h8FFF_FFF0);
      reg_write(2'd1, 32'hFFFF_FFFF);
      reg_check("R2 pos mask", 2'd1, 32'h0FFF_0FFF);
      reg_write(2'd3, 32'hABCD_8A55);
      reg_check("R2 colour C mask", 2'd3, 32'h0000_8A55);
      reg_write(2'd2, 32'h07E0_F800);
      reg_check("R2 colour AB", 2'd2, 32'h07E0_F800);
      reg_write(2'd1, 32'h0032_0064);
      reg_check("R2 pos value", 2'd1, 32'h0032_0064);

      // R3: disabled cursor passes background, even at a code-1 pixel
      reg_write(2'd0, 32'h0000_1230);
      reg_check("R2 ctrl off", 2'd0, 32'h0000_1230);
      apply("R3 disabled", 12'd101, 12'd50, 24'h123456, 24'h123456);

      reg_write(2'd0, 32'h8000_1230);
      reg_check("R2 ctrl on", 2'd0, 32'h8000_1230);

      // R5 R6 R7 R8 R9 vector walk
      for (int i = 0; i < NVEC; i++) begin
         logic [23:0] exp;
         case (VEC[i][1:0])
            2'd1:    exp = EXP_A;
            2'd2:    exp = EXP_B;
            2'd3:    exp = EXP_C;
            default: exp = VEC[i][25:2];
         endcase
         apply("R5 R6 R7 R8 R9 overlay", VEC[i][49:38], VEC[i][37:26], VEC[i][25:2], exp);
      end

      // R4: valid drops one cycle later
      @(negedge clk);
      pix_valid = 1'b0; pix_hsync = 1'b0; pix_vsync = 1'b0;
      @(negedge clk);
      check("R4 valid low", {29'h0, out_valid, out_hsync, out_vsync}, 32'h0);

      // R7: new colour A takes effect on the next pixel
      reg_write(2'd2, 32'h07E0_001F);
      apply("R7 R8 colour A update", 12'd101, 12'd50, 24'h010203, 24'h0000F8);

      done = 1'b1;
      summary();
   end
endmodule